// File: doc/BRIEF.md
# PLL dynamic phase shift controller

This block lives in user logic next to a multi-output PLL. It turns a simple request into a correctly ordered dynamic phase-shift sequence on the PLL's control pins. The request is a five-bit output mask, a three-bit phase code and a one-cycle go strobe. Each step of the code delays the selected outputs by half a period of the post-divider PLL clock. Code 0 gives no shift and code 7 gives three and a half periods. Any subset of the five outputs may be shifted by one command.

When a request is accepted, the block latches the mask, the code, the pulse length and the lock-wait choice. It drives the code and mask onto the PLL for one set-up cycle, raises the shift enable for a programmable number of cycles, and keeps the code and mask steady for one hold cycle. It can then wait for a synchronized lock indication. Last, it pulses done for one cycle. A request with an empty mask is refused with a one-cycle error pulse. A request made while the configuration flag says the PLL runs on internal feedback is refused the same way, because that mode cannot phase-shift. Requests that arrive while a command is in progress are ignored.

Top module: `pll_phase_shift_ctrl`

## Requirements
- R1: Out of reset, shift_ena, busy, done and err are 0, and shift_val and shift_sel are all zeros.
- R2: When go is sampled high in idle with a nonzero mask and ext_fbk_mode high, the command is accepted. From the next cycle, shift_sel equals the mask (bit i selects output i) and shift_val equals the code (code k means k half-periods of delay). Both stay unchanged until the next accepted command.
- R3: shift_ena is low for exactly one cycle after acceptance, with value and mask already driven, and is low for one hold cycle after it falls. Value and mask never change in the cycle shift_ena rises or falls.
- R4: shift_ena is one continuous pulse per accepted command. Its length is pulse_len cycles, sampled with the command; pulse_len = 0 selects the default of 2 cycles.
- R5: A go in idle with an all-zero mask is rejected. err is high for exactly the next cycle, and shift_ena, busy, shift_val and shift_sel are unaffected.
- R6: A go in idle while ext_fbk_mode is low is rejected exactly as in R5.
- R7: A go while busy is high, including the cycle in which done is high, is ignored. It causes no err, no new shift_ena and no change of shift_val or shift_sel.
- R8: With lock waiting off, done is a single-cycle pulse in the second cycle after shift_ena falls. busy is high from the cycle after acceptance through the done cycle.
- R9: With wait_lock high at acceptance, done is withheld while pll_locked is low. Once pll_locked rises, done pulses in the third cycle, after a two-stage synchronizer. If the synchronized lock is already high, done comes as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_fbk_mode | input | 1 | High when the PLL uses external feedback, so shifting is allowed |
| req_go | input | 1 | One-cycle command strobe |
| req_mask | input | 5 | Outputs to shift |
| req_code | input | 3 | Phase code in half-period steps |
| pulse_len | input | 4 | Enable pulse length in cycles, 0 = default 2 |
| wait_lock | input | 1 | Wait for PLL lock before done |
| pll_locked | input | 1 | Asynchronous PLL lock indication |
| shift_val | output | 3 | Phase value to PLL |
| shift_sel | output | 5 | Output selection to PLL |
| shift_ena | output | 1 | Shift enable to PLL |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The completion pulse and a fresh request can fall in the same cycle. The bench raises go with a different mask and code exactly in the cycle where done is high. It then checks that no enable follows, that no error appears and that the driven value and mask keep the finished command's values. A request arriving while the controller waits for lock is judged the same way. Every mask and code pair is swept with pulse lengths derived from the pair, and each sample of enable, done and busy is compared against cycle positions computed from the pulse length.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LOCKW = 3'd4,
    ST_DONE  = 3'd5
  } pps_state_e;

  // Effective enable length: a request of zero falls back to the default.
  function automatic int unsigned eff_pulse_len(int unsigned req, int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

  // A command is acceptable when some output is chosen and feedback is external.
  function automatic logic cmd_ok(logic mask_nonzero, logic fbk_external);
    return mask_nonzero & fbk_external;
  endfunction

endpackage

// File: rtl/pps_lock_sync.sv
module pps_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/pps_pulse_timer.sv
module pps_pulse_timer #(
  parameter int PLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PLEN_W-1:0] len,
  output logic              active,
  output logic              last
);
  logic [PLEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= len - 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last = active && (cnt == '0);

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) load |-> !active);
endmodule

// File: rtl/pps_seq.sv
module pps_seq
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       mask_nz,
  input  logic       fbk_ok,
  input  logic       wait_lock,
  input  logic       lock_s,
  input  logic       pulse_last,
  output pps_state_e state,
  output logic       accept,
  output logic       reject,
  output logic       load_timer,
  output logic       busy,
  output logic       done
);
  pps_state_e nxt;
  logic       wl_q;
  logic       idle_go;

  assign idle_go    = (state == ST_IDLE) && go;
  assign accept     = idle_go && cmd_ok(mask_nz, fbk_ok);
  assign reject     = idle_go && !cmd_ok(mask_nz, fbk_ok);
  assign load_timer = (state == ST_SETUP);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (accept) nxt = ST_SETUP;
      ST_SETUP: nxt = ST_PULSE;
      ST_PULSE: if (pulse_last) nxt = ST_HOLD;
      ST_HOLD:  nxt = (!wl_q || lock_s) ? ST_DONE : ST_LOCKW;
      ST_LOCKW: if (lock_s) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wl_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) wl_q <= wait_lock;
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && wl_q) |-> $past(lock_s));
endmodule

// File: rtl/pll_phase_shift_ctrl.sv
module pll_phase_shift_ctrl
  import pps_pkg::*;
#(
  parameter int NUM_OUT       = 5,
  parameter int CODE_W        = 3,
  parameter int PLEN_W        = 4,
  parameter int DEFAULT_PULSE = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_fbk_mode,
  input  logic              req_go,
  input  logic [NUM_OUT-1:0] req_mask,
  input  logic [CODE_W-1:0] req_code,
  input  logic [PLEN_W-1:0] pulse_len,
  input  logic              wait_lock,
  input  logic              pll_locked,
  output logic [CODE_W-1:0] shift_val,
  output logic [NUM_OUT-1:0] shift_sel,
  output logic              shift_ena,
  output logic              busy,
  output logic              done,
  output logic              err
);
  pps_state_e        state;
  logic              accept, reject, load_timer, pulse_last, lock_s;
  logic [PLEN_W-1:0] len_eff, len_q;
  logic [CODE_W-1:0] val_q;
  logic [NUM_OUT-1:0] sel_q;
  logic              err_q;

  assign len_eff = PLEN_W'(eff_pulse_len(int'(pulse_len), DEFAULT_PULSE));

  pps_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pll_locked), .dout(lock_s)
  );

  pps_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(req_go), .mask_nz(|req_mask),
    .fbk_ok(ext_fbk_mode), .wait_lock(wait_lock), .lock_s(lock_s),
    .pulse_last(pulse_last), .state(state), .accept(accept), .reject(reject),
    .load_timer(load_timer), .busy(busy), .done(done)
  );

  pps_pulse_timer #(.PLEN_W(PLEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load_timer), .len(len_q),
    .active(shift_ena), .last(pulse_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      sel_q <= '0;
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= reject;
      if (accept) begin
        val_q <= req_code;
        sel_q <= req_mask;
        len_q <= len_eff;
      end
    end
  end

  assign shift_val = val_q;
  assign shift_sel = sel_q;
  assign err       = err_q;

  // R3
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_ena) |-> ($stable(shift_val) && $stable(shift_sel)));
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_ena) |-> ($stable(shift_val) && $stable(shift_sel)));
  // R2
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ena |-> (shift_sel != '0));
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !shift_ena);
endmodule

// File: tb/pll_phase_shift_ctrl_tb.sv
module pll_phase_shift_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_fbk_mode = 1'b1, req_go = 1'b0, wait_lock = 1'b0, pll_locked = 1'b1;
  logic [4:0] req_mask = '0;
  logic [2:0] req_code = '0;
  logic [3:0] pulse_len = '0;
  logic [2:0] shift_val;
  logic [4:0] shift_sel;
  logic shift_ena, busy, done, err;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_phase_shift_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_fbk_mode(ext_fbk_mode), .req_go(req_go),
    .req_mask(req_mask), .req_code(req_code), .pulse_len(pulse_len),
    .wait_lock(wait_lock), .pll_locked(pll_locked), .shift_val(shift_val),
    .shift_sel(shift_sel), .shift_ena(shift_ena), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one accepted command; samples at falling edges, s=1 is the cycle after acceptance.
  task automatic run_cmd(input logic [4:0] m, input logic [2:0] c, input logic [3:0] pl,
                         input logic wl, input bit go_in_done);
    int n = (pl == 0) ? 2 : int'(pl);
    @(negedge clk);
    req_go = 1; req_mask = m; req_code = c; pulse_len = pl; wait_lock = wl;
    @(negedge clk);
    req_go = 0;
    for (int s = 1; s <= n + 3; s++) begin
      bit exp_ena = (s >= 2) && (s <= n + 1);
      string tg = (s == 1 || s == n + 2) ? "R3" : "R4";
      if (s > 1) @(negedge clk);
      chk(shift_sel == m, "R2", shift_sel, m);
      chk(shift_val == c, "R2", shift_val, c);
      chk(shift_ena == exp_ena, tg, shift_ena, exp_ena);
      chk(done == (s == n + 3), "R8", done, s == n + 3);
      chk(busy == 1'b1, "R8", busy, 1);
      if (s == n + 3 && go_in_done) begin
        req_go = 1; req_mask = ~m; req_code = ~c;
      end
    end
    @(negedge clk);
    req_go = 0;
    chk(done == 0, "R8", done, 0);
    chk(busy == 0, go_in_done ? "R7" : "R8", busy, 0);
    if (go_in_done) begin
      for (int k = 0; k < 4; k++) begin
        chk(!shift_ena && !err && !busy, "R7", {shift_ena, err, busy}, 0);
        chk(shift_sel == m && shift_val == c, "R7", {shift_sel, shift_val}, {m, c});
        @(negedge clk);
      end
    end
  endtask

  task automatic reject_cmd(input logic [4:0] m, input logic fbk, input string tg);
    logic [4:0] s0 = shift_sel;
    logic [2:0] v0 = shift_val;
    @(negedge clk);
    ext_fbk_mode = fbk; req_go = 1; req_mask = m; req_code = 3'd5;
    @(negedge clk);
    req_go = 0;
    chk(err == 1, tg, err, 1);
    chk(!busy && !shift_ena, tg, {busy, shift_ena}, 0);
    chk(shift_sel == s0 && shift_val == v0, tg, {shift_sel, shift_val}, {s0, v0});
    @(negedge clk);
    chk(err == 0, tg, err, 0);
    for (int k = 0; k < 3; k++) begin
      chk(!busy && !shift_ena, tg, {busy, shift_ena}, 0);
      @(negedge clk);
    end
    ext_fbk_mode = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk({shift_ena, busy, done, err} == 0, "R1", {shift_ena, busy, done, err}, 0);
    chk(shift_val == 0 && shift_sel == 0, "R1", {shift_sel, shift_val}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({shift_ena, busy, done, err} == 0, "R1", {shift_ena, busy, done, err}, 0);

    // Sweep all masks and codes, pulse lengths derived from the pair
    for (int m = 1; m < 32; m++)
      for (int c = 0; c < 8; c++)
        run_cmd(5'(m), 3'(c), 4'((m + c) % 5), 1'b0, 1'b0);
    run_cmd(5'b10101, 3'd7, 4'd15, 1'b0, 1'b0);

    // R7 go in the done cycle
    run_cmd(5'b00110, 3'd3, 4'd0, 1'b0, 1'b1);
    run_cmd(5'b11111, 3'd1, 4'd3, 1'b0, 1'b1);

    // R5 empty mask, R6 internal feedback
    reject_cmd(5'b00000, 1'b1, "R5");
    reject_cmd(5'b01000, 1'b0, "R6");

    // R9 lock already high
    run_cmd(5'b00001, 3'd2, 4'd1, 1'b1, 1'b0);

    // R9 wait for lock, with R7 go during the wait
    pll_locked = 0;
    repeat (4) @(negedge clk);
    req_go = 1; req_mask = 5'b10010; req_code = 3'd6; pulse_len = 0; wait_lock = 1;
    @(negedge clk);
    req_go = 0;
    for (int s = 1; s <= 4; s++) begin
      chk(shift_ena == (s >= 2 && s <= 3), "R4", shift_ena, s >= 2 && s <= 3);
      @(negedge clk);
    end
    for (int k = 0; k < 10; k++) begin
      chk(busy && !done, "R9", {busy, done}, 2);
      if (k == 3) begin req_go = 1; req_mask = 5'b00001; req_code = 3'd0; end
      if (k == 4) begin
        req_go = 0;
        chk(!err && shift_sel == 5'b10010 && shift_val == 3'd6, "R7",
            {err, shift_sel, shift_val}, {1'b0, 5'b10010, 3'd6});
      end
      @(negedge clk);
    end
    pll_locked = 1;
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      chk(done == (s == 3), "R9", done, s == 3);
    end
    chk(!busy, "R9", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule